// File: doc/BRIEF.md
# March Memory Self-Test Engine

This block is a hardware self-test sequencer for a byte-wide synchronous RAM. The address space is split into fixed-size blocks, and each block has its own enable bit. After a start request the engine first finds out which blocks respond as writable storage. It then runs a repeating march over every location that is both present and enabled. For each background value, the march fills memory, then makes an ascending read-compare-invert sweep and then a descending read-compare-invert sweep.

Each miscompare increments a saturating error counter and updates the logged failing address, the value read, the value expected and the value written over it. It also sets sticky per-bit flags for the region that holds the address. These flags tell wrongly-low bits from wrongly-high bits. A stop-on-error mode freezes the engine after the failing location so the logs can be read out. The go mode keeps running and only accumulates results. A loop counter shows how many complete pattern sequences have finished.

Top module: `march_bist`

## Requirements
- R1: After `start`, the engine probes address offset 0 of every block in ascending block order. It reads the byte, writes back its bitwise inverse, and reads it again. `presentMask` bit n is set when the second read differs from the first in at least one bit.
- R2: For each background value P, the engine first writes P to every active location. It then visits the active locations in ascending address order, reading each one, comparing it with P and writing ~P. A read and a write are never issued in the same cycle.
- R3: After the ascending sweep, the engine visits the active locations in descending address order. It reads each one, compares it with ~P and writes P.
- R4: The background value with index k (k = 0 to NUM_PAT-1) is (2^k)-1, so the default sequence runs from 0x00 up to 0x7F. `loopCount` increments once after the descending sweep of the last value, and the sequence then starts again at k = 0.
- R5: A location is active only when its block has both `presentMask` and `userMask` set. In the test phases an inactive location gets no read and no write. Each inactive location takes one cycle per sweep, and each active location takes two cycles in each compare sweep.
- R6: Each miscompare adds one to `errCount`, which saturates at all ones. It also sets `lastAddr`, `lastAct` and `lastExp`, and sets `lastOvr` to the value written back at that location (the inverse of the expected value).
- R7: `stuckMap` holds 2 bits for bit b of region r at index 2*(r*DATA_W+b). The low bit records a read of 0 where 1 was expected, and the high bit records a read of 1 where 0 was expected. The flags are sticky and are cleared only as R10 and R11 describe.
- R8: With `stopOnErr` high, a miscompare stops the engine after the write-back of that location, and `halted` goes high. While it is halted no memory access is issued. A `resume` pulse continues with the next location.
- R9: With `stopOnErr` low, the engine never halts, and `errCount` keeps adding up over successive loops.
- R10: Any change of `userMask` clears `errCount`, the logged values, `stuckMap` and `loopCount` on that clock edge. If a test phase is running, it restarts with the fill of the first background value at address 0.
- R11: After reset the engine is idle, with `busy`, `halted`, every counter, every log and `presentMask` at zero. A `start` pulse clears the logs and begins the probe. A `haltReq` pulse returns the engine to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin probe and test (while idle) |
| haltReq | input | 1 | Return to idle |
| resume | input | 1 | Continue after a stop on error |
| stopOnErr | input | 1 | 1: halt at a miscompare, 0: keep running |
| userMask | input | NUM_BLK | Per-block test enable |
| busy | output | 1 | Engine not idle |
| halted | output | 1 | Stopped on a miscompare |
| presentMask | output | NUM_BLK | Blocks found writable by the probe |
| errCount | output | ERR_W | Saturating miscompare count |
| lastAddr | output | ADDR_W | Address of the latest miscompare |
| lastAct | output | DATA_W | Value read at the latest miscompare |
| lastExp | output | DATA_W | Value expected at the latest miscompare |
| lastOvr | output | DATA_W | Value written back at the latest miscompare |
| stuckMap | output | NUM_REG*DATA_W*2 | Per-region, per-bit stuck flags |
| loopCount | output | LOOP_W | Completed pattern sequences |
| memAddr | output | ADDR_W | RAM address |
| memRe | output | 1 | RAM read enable; data returns one cycle later |
| memWe | output | 1 | RAM write enable |
| memWdata | output | DATA_W | RAM write data |
| memRdata | input | DATA_W | RAM read data |

## Verification
The hardest state to reach from the ports is a miscompare whose kind and position depend on both the background value and the sweep direction. The bench's RAM model therefore has one bit stuck high at one address and one bit stuck low at an address in another region, together with two absent blocks and one block disabled by the user. A small reference walk in the bench follows the visit order and predicts the error count, the last logged miscompare and the stuck map for a full loop. Stop mode is then used to freeze the engine at exactly the first ascending-sweep fault and at the first descending-sweep fault. A mask change made in the middle of a loop shows whether the engine restarts from the first pattern.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PR_RD, S_PR_WR, S_PR_RD2, S_PR_EV,
    S_FILL, S_FW_RD, S_FW_CMP, S_BW_RD, S_BW_CMP, S_HALT
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrLog;
    logic clrPresent;
    logic capOrig;
    logic probeEval;
    logic cmpEn;
    logic loopInc;
  } strobeT;

endpackage

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLK_W   = 10,
  parameter int DATA_W  = 8,
  parameter int NUM_PAT = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          haltReq,
  input  logic                          resume,
  input  logic                          stopOnErr,
  input  logic [(1<<(ADDR_W-BLK_W))-1:0] userMask,
  input  logic [(1<<(ADDR_W-BLK_W))-1:0] presentMask,
  input  logic                          mismatch,
  input  logic [DATA_W-1:0]             memRdata,
  output strobeT                        strb,
  output logic [ADDR_W-1:0]             curAddr,
  output logic [DATA_W-1:0]             expVal,
  output logic [ADDR_W-1:0]             memAddr,
  output logic                          memRe,
  output logic                          memWe,
  output logic [DATA_W-1:0]             memWdata,
  output logic                          busy,
  output logic                          halted
);

  localparam int NUM_BLK = 1 << (ADDR_W - BLK_W);
  localparam int PAT_W   = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
  localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(1) << BLK_W;
  localparam logic [PAT_W-1:0]  PAT_LAST = PAT_W'(NUM_PAT - 1);

  stateT state, stateN, retState, retN, nxt;
  logic [ADDR_W-1:0] addr, addrN;
  logic [PAT_W-1:0]  patIdx, patN;
  logic [NUM_BLK-1:0] userMaskQ;
  logic [DATA_W:0]   patWide;
  logic [DATA_W-1:0] pat;
  logic [ADDR_W-BLK_W-1:0] blkIdx;
  logic addrEn, lastAddr, firstAddr, maskChanged, inTest;

  assign blkIdx      = addr[ADDR_W-1:BLK_W];
  assign addrEn      = presentMask[blkIdx] & userMaskQ[blkIdx];
  assign lastAddr    = &addr;
  assign firstAddr   = (addr == '0);
  assign maskChanged = (userMask != userMaskQ);
  assign inTest      = state inside {S_FILL, S_FW_RD, S_FW_CMP, S_BW_RD, S_BW_CMP, S_HALT};
  assign patWide     = ((DATA_W+1)'(1) << patIdx) - (DATA_W+1)'(1);
  assign pat         = patWide[DATA_W-1:0];

  always_comb begin
    stateN   = state;
    addrN    = addr;
    patN     = patIdx;
    retN     = retState;
    nxt      = state;
    strb     = '0;
    memRe    = 1'b0;
    memWe    = 1'b0;
    memWdata = pat;
    expVal   = pat;
    case (state)
      S_IDLE: if (start) begin
        stateN = S_PR_RD;
        addrN  = '0;
        patN   = '0;
        strb.clrLog     = 1'b1;
        strb.clrPresent = 1'b1;
      end
      S_PR_RD: begin
        memRe  = 1'b1;
        stateN = S_PR_WR;
      end
      S_PR_WR: begin
        memWe        = 1'b1;
        memWdata     = ~memRdata;
        strb.capOrig = 1'b1;
        stateN       = S_PR_RD2;
      end
      S_PR_RD2: begin
        memRe  = 1'b1;
        stateN = S_PR_EV;
      end
      S_PR_EV: begin
        strb.probeEval = 1'b1;
        if (&blkIdx) begin
          stateN = S_FILL;
          addrN  = '0;
        end else begin
          stateN = S_PR_RD;
          addrN  = addr + BLK_STEP;
        end
      end
      S_FILL: begin
        memWe = addrEn;
        if (lastAddr) begin
          stateN = S_FW_RD;
          addrN  = '0;
        end else addrN = addr + ADDR_W'(1);
      end
      S_FW_RD: begin
        if (addrEn) begin
          memRe  = 1'b1;
          stateN = S_FW_CMP;
        end else if (lastAddr) stateN = S_BW_RD;
        else addrN = addr + ADDR_W'(1);
      end
      S_FW_CMP: begin
        strb.cmpEn = 1'b1;
        memWe      = 1'b1;
        memWdata   = ~pat;
        nxt        = lastAddr ? S_BW_RD : S_FW_RD;
        if (!lastAddr) addrN = addr + ADDR_W'(1);
        if (mismatch && stopOnErr) begin
          stateN = S_HALT;
          retN   = nxt;
        end else stateN = nxt;
      end
      S_BW_RD: begin
        expVal = ~pat;
        if (addrEn) begin
          memRe  = 1'b1;
          stateN = S_BW_CMP;
        end else if (firstAddr) begin
          stateN = S_FILL;
          patN   = (patIdx == PAT_LAST) ? '0 : patIdx + PAT_W'(1);
          strb.loopInc = (patIdx == PAT_LAST);
        end else addrN = addr - ADDR_W'(1);
      end
      S_BW_CMP: begin
        expVal     = ~pat;
        strb.cmpEn = 1'b1;
        memWe      = 1'b1;
        memWdata   = pat;
        if (firstAddr) begin
          nxt  = S_FILL;
          patN = (patIdx == PAT_LAST) ? '0 : patIdx + PAT_W'(1);
          strb.loopInc = (patIdx == PAT_LAST);
        end else begin
          nxt   = S_BW_RD;
          addrN = addr - ADDR_W'(1);
        end
        if (mismatch && stopOnErr) begin
          stateN = S_HALT;
          retN   = nxt;
        end else stateN = nxt;
      end
      S_HALT: if (resume) stateN = retState;
      default: stateN = S_IDLE;
    endcase
    // a new block selection invalidates results and restarts the march
    if (maskChanged) begin
      strb.clrLog = 1'b1;
      if (inTest) begin
        stateN = S_FILL;
        addrN  = '0;
        patN   = '0;
      end
    end
    if (haltReq) stateN = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      retState  <= S_IDLE;
      addr      <= '0;
      patIdx    <= '0;
      userMaskQ <= '0;
    end else begin
      state     <= stateN;
      retState  <= retN;
      addr      <= addrN;
      patIdx    <= patN;
      userMaskQ <= userMask;
    end
  end

  assign curAddr = addr;
  assign memAddr = addr;
  assign busy    = (state != S_IDLE);
  assign halted  = (state == S_HALT);

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memWe && !memRe)); // R8
  AST_IDLE_AFTER_HALTREQ: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> !busy); // R11
  AST_NO_READ_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R2
  AST_SKIP_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    ((memWe || memRe) && inTest && !maskChanged)
      |-> (userMask[memAddr[ADDR_W-1:BLK_W]] && presentMask[memAddr[ADDR_W-1:BLK_W]])); // R5

endmodule

// File: rtl/march_dpath.sv
module march_dpath
  import march_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLK_W    = 10,
  parameter int REGION_W = 12,
  parameter int DATA_W   = 8,
  parameter int ERR_W    = 16,
  parameter int LOOP_W   = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  strobeT                               strb,
  input  logic [ADDR_W-1:0]                    curAddr,
  input  logic [DATA_W-1:0]                    expVal,
  input  logic [DATA_W-1:0]                    memRdata,
  output logic                                 mismatch,
  output logic [(1<<(ADDR_W-BLK_W))-1:0]       presentMask,
  output logic [ERR_W-1:0]                     errCount,
  output logic [ADDR_W-1:0]                    lastAddr,
  output logic [DATA_W-1:0]                    lastAct,
  output logic [DATA_W-1:0]                    lastExp,
  output logic [DATA_W-1:0]                    lastOvr,
  output logic [(1<<(ADDR_W-REGION_W))*DATA_W*2-1:0] stuckMap,
  output logic [LOOP_W-1:0]                    loopCount
);

  localparam int NUM_REG   = 1 << (ADDR_W - REGION_W);
  localparam int REG_IDX_W = ADDR_W - REGION_W;
  localparam int STUCK_W   = NUM_REG * DATA_W * 2;

  logic [DATA_W-1:0]  origQ;
  logic [NUM_REG-1:0] regHit;
  logic [STUCK_W-1:0] stuckSet;
  logic               logHit;

  assign mismatch = (memRdata != expVal);
  assign logHit   = strb.cmpEn & mismatch;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    assign regHit[r] = (curAddr[ADDR_W-1:REGION_W] == REG_IDX_W'(r));
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign stuckSet[(r*DATA_W+b)*2]   = regHit[r] & expVal[b] & ~memRdata[b];
      assign stuckSet[(r*DATA_W+b)*2+1] = regHit[r] & ~expVal[b] & memRdata[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      origQ       <= '0;
      presentMask <= '0;
    end else begin
      if (strb.capOrig) origQ <= memRdata;
      if (strb.clrPresent) presentMask <= '0;
      else if (strb.probeEval)
        presentMask[curAddr[ADDR_W-1:BLK_W]] <= (memRdata != origQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount  <= '0;
      lastAddr  <= '0;
      lastAct   <= '0;
      lastExp   <= '0;
      lastOvr   <= '0;
      stuckMap  <= '0;
      loopCount <= '0;
    end else if (strb.clrLog) begin
      errCount  <= '0;
      lastAddr  <= '0;
      lastAct   <= '0;
      lastExp   <= '0;
      lastOvr   <= '0;
      stuckMap  <= '0;
      loopCount <= '0;
    end else begin
      if (logHit) begin
        if (errCount != '1) errCount <= errCount + ERR_W'(1);
        lastAddr <= curAddr;
        lastAct  <= memRdata;
        lastExp  <= expVal;
        lastOvr  <= ~expVal;
        stuckMap <= stuckMap | stuckSet;
      end
      if (strb.loopInc) loopCount <= loopCount + LOOP_W'(1);
    end
  end

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmpEn && mismatch && !strb.clrLog && errCount != '1)
      |=> errCount == $past(errCount) + ERR_W'(1)); // R6
  AST_STUCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrLog |=> ((stuckMap & $past(stuckMap)) == $past(stuckMap))); // R7
  AST_CLEAR_LOGS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrLog |=> (errCount == '0 && loopCount == '0 && stuckMap == '0)); // R10
  AST_LOOP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loopInc && !strb.clrLog) |=> loopCount == $past(loopCount) + LOOP_W'(1)); // R4

endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLK_W    = 10,
  parameter int REGION_W = 12,
  parameter int DATA_W   = 8,
  parameter int NUM_PAT  = 8,
  parameter int ERR_W    = 16,
  parameter int LOOP_W   = 16,
  localparam int NUM_BLK = 1 << (ADDR_W - BLK_W),
  localparam int NUM_REG = 1 << (ADDR_W - REGION_W),
  localparam int STUCK_W = NUM_REG * DATA_W * 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               haltReq,
  input  logic               resume,
  input  logic               stopOnErr,
  input  logic [NUM_BLK-1:0] userMask,
  output logic               busy,
  output logic               halted,
  output logic [NUM_BLK-1:0] presentMask,
  output logic [ERR_W-1:0]   errCount,
  output logic [ADDR_W-1:0]  lastAddr,
  output logic [DATA_W-1:0]  lastAct,
  output logic [DATA_W-1:0]  lastExp,
  output logic [DATA_W-1:0]  lastOvr,
  output logic [STUCK_W-1:0] stuckMap,
  output logic [LOOP_W-1:0]  loopCount,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memRe,
  output logic               memWe,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdata
);

  strobeT            strb;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] expVal;
  logic              mismatch;

  march_ctrl #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W), .NUM_PAT(NUM_PAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .haltReq(haltReq),
    .resume(resume), .stopOnErr(stopOnErr), .userMask(userMask),
    .presentMask(presentMask), .mismatch(mismatch), .memRdata(memRdata),
    .strb(strb), .curAddr(curAddr), .expVal(expVal), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .busy(busy), .halted(halted)
  );

  march_dpath #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .REGION_W(REGION_W), .DATA_W(DATA_W),
    .ERR_W(ERR_W), .LOOP_W(LOOP_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .curAddr(curAddr),
    .expVal(expVal), .memRdata(memRdata), .mismatch(mismatch),
    .presentMask(presentMask), .errCount(errCount), .lastAddr(lastAddr),
    .lastAct(lastAct), .lastExp(lastExp), .lastOvr(lastOvr),
    .stuckMap(stuckMap), .loopCount(loopCount)
  );

endmodule

// File: tb/sim_march_bist.sv
module sim_march_bist;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, BW = 2, RW = 3, DW = 8;
  localparam int NLOC = 1 << AW;
  localparam int FHI_ADDR = 13, FHI_BIT = 6;  // bit stuck high
  localparam int FLO_ADDR = 40, FLO_BIT = 0;  // bit stuck low
  localparam logic [15:0] ABSENT = 16'h4200;  // blocks 9 and 14

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 0, haltReq = 0, resume = 0, stopOnErr = 0;
  logic [15:0]  userMask = 16'hFFDF;
  logic         busy, halted, memRe, memWe;
  logic [15:0]  presentMask, errCount, loopCount;
  logic [AW-1:0] lastAddr, memAddr;
  logic [DW-1:0] lastAct, lastExp, lastOvr, memWdata, memRdata;
  logic [127:0] stuckMap;

  logic [7:0] mem [NLOC];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  march_bist #(.ADDR_W(AW), .BLK_W(BW), .REGION_W(RW), .DATA_W(DW),
               .NUM_PAT(8), .ERR_W(16), .LOOP_W(16)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .haltReq(haltReq),
    .resume(resume), .stopOnErr(stopOnErr), .userMask(userMask),
    .busy(busy), .halted(halted), .presentMask(presentMask),
    .errCount(errCount), .lastAddr(lastAddr), .lastAct(lastAct),
    .lastExp(lastExp), .lastOvr(lastOvr), .stuckMap(stuckMap),
    .loopCount(loopCount), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [7:0] faultVal(int a, logic [7:0] v);
    logic [7:0] r;
    r = v;
    if (a == FHI_ADDR) r[FHI_BIT] = 1'b1;
    if (a == FLO_ADDR) r[FLO_BIT] = 1'b0;
    return r;
  endfunction

  // faulty synchronous RAM with absent blocks
  always @(posedge clk) begin
    if (memRe) memRdata <= ABSENT[memAddr >> BW] ? 8'hFF : mem[memAddr];
    if (memWe && !ABSENT[memAddr >> BW]) mem[memAddr] <= faultVal(int'(memAddr), memWdata);
  end

  // monitors
  bit recordEn = 0;
  int wrN = 0, loopCycles = 0, ascN = 0, descN = 0, haltAccess = 0;
  int prevRd = 0;
  logic [7:0] wrLog [64];
  always @(negedge clk) begin
    if (halted && (memWe || memRe)) haltAccess++;
    if (recordEn && loopCount == 1) begin
      loopCycles++;
      if (memWe && memAddr == 1 && wrN < 64) begin
        wrLog[wrN] = memWdata;
        wrN++;
      end
      if (memRe) begin
        if (int'(memAddr) > prevRd) ascN++;
        if (int'(memAddr) < prevRd) descN++;
      end
    end
    if (memRe) prevRd = int'(memAddr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference walk over one full loop
  int refCnt;
  logic [AW-1:0] refAddr;
  logic [7:0] refAct, refExp, refOvr;
  logic [127:0] refStuck;

  task automatic refCmp(int a, logic [7:0] e);
    logic [7:0] act;
    act = faultVal(a, e);
    if (act != e) begin
      refCnt++;
      refAddr = AW'(a); refAct = act; refExp = e; refOvr = ~e;
      for (int b = 0; b < 8; b++) begin
        if (e[b] && !act[b]) refStuck[((a >> RW)*8 + b)*2] = 1'b1;
        if (!e[b] && act[b]) refStuck[((a >> RW)*8 + b)*2 + 1] = 1'b1;
      end
    end
  endtask

  task automatic refLoop(input logic [15:0] en);
    logic [7:0] p;
    refCnt = 0; refStuck = '0; refAddr = '0; refAct = '0; refExp = '0; refOvr = '0;
    for (int k = 0; k < 8; k++) begin
      p = 8'((9'd1 << k) - 9'd1);
      for (int a = 0; a < NLOC; a++) if (en[a >> BW]) refCmp(a, p);
      for (int a = NLOC-1; a >= 0; a--) if (en[a >> BW]) refCmp(a, ~p);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [15:0] en;
    int nEn;
    for (int a = 0; a < NLOC; a++) mem[a] = 8'(a*37 + 5);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !halted, "R11", "idle after reset", {busy, halted}, 0);
    check(errCount == 0 && loopCount == 0, "R11", "counters after reset", {errCount, loopCount}, 0);
    check(presentMask == 0 && stuckMap == 0, "R11", "masks after reset", presentMask, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memWe && !memRe, "R11", "no access while idle", {memWe, memRe}, 0);

    // run 1: go mode with faults
    recordEn = 1;
    start = 1; @(negedge clk); start = 0;
    check(busy, "R11", "busy after start", busy, 1);
    en = 16'hBDFF & userMask;
    nEn = 4 * $countones(en);
    refLoop(en);
    while (loopCount != 1) @(negedge clk);
    check(presentMask == 16'hBDFF, "R1", "present mask", presentMask, 16'hBDFF);
    check(errCount == 16'(refCnt), "R6", "errors after one loop", errCount, refCnt);
    check(lastAddr == refAddr && lastAct == refAct, "R6", "last addr/actual",
          {lastAddr, lastAct}, {refAddr, refAct});
    check(lastExp == refExp && lastOvr == refOvr, "R6", "last expected/overwrite",
          {lastExp, lastOvr}, {refExp, refOvr});
    check(stuckMap == refStuck, "R7", "stuck map", stuckMap, refStuck);
    while (loopCount != 2) @(negedge clk);
    recordEn = 0;
    check(errCount == 16'(2*refCnt), "R9", "errors accumulate over loops", errCount, 2*refCnt);
    check(loopCycles == 8*(NLOC + 2*(NLOC + nEn)), "R5", "loop length",
          loopCycles, 8*(NLOC + 2*(NLOC + nEn)));
    check(wrN == 24, "R4", "writes to addr 1 per loop", wrN, 24);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] p;
      p = 8'((9'd1 << k) - 9'd1);
      check(wrLog[3*k] == p, "R2", "fill value", wrLog[3*k], p);
      check(wrLog[3*k+1] == ~p, "R2", "ascending write-back", wrLog[3*k+1], ~p);
      check(wrLog[3*k+2] == p, "R3", "descending write-back", wrLog[3*k+2], p);
    end
    check(ascN == 8*(nEn-1), "R2", "ascending read steps", ascN, 8*(nEn-1));
    check(descN == 8*(nEn-1), "R3", "descending read steps", descN, 8*(nEn-1));
    haltReq = 1; @(negedge clk); haltReq = 0;
    check(!busy, "R11", "idle after haltReq", busy, 0);
    for (int a = 21; a < 24; a++)
      check(mem[a] == 8'(a*37 + 5), "R5", "disabled block untouched", mem[a], 8'(a*37 + 5));
    check(mem[20] == ~8'(20*37 + 5), "R1", "probe inverted block base", mem[20], ~8'(20*37 + 5));

    // run 2: stop on error
    stopOnErr = 1;
    start = 1; @(negedge clk); start = 0;
    check(errCount == 0, "R11", "start clears log", errCount, 0);
    while (!halted) @(negedge clk);
    check(errCount == 1 && lastAddr == AW'(FHI_ADDR), "R8", "first halt location",
          {errCount, lastAddr}, {16'd1, 6'(FHI_ADDR)});
    check(lastAct == 8'h40 && lastExp == 8'h00 && lastOvr == 8'hFF, "R6", "first halt values",
          {lastAct, lastExp, lastOvr}, 24'h4000FF);
    repeat (5) @(negedge clk);
    check(halted && haltAccess == 0, "R8", "quiet while halted", {halted, 8'(haltAccess)}, 9'h100);
    resume = 1; @(negedge clk); resume = 0;
    while (!halted) @(negedge clk);
    check(errCount == 2 && lastAddr == AW'(FLO_ADDR), "R8", "second halt (descending) location",
          {errCount, lastAddr}, {16'd2, 6'(FLO_ADDR)});
    check(lastAct == 8'hFE && lastExp == 8'hFF && lastOvr == 8'h00, "R3", "descending expected value",
          {lastAct, lastExp, lastOvr}, 24'hFEFF00);

    // mask change while running in go mode
    stopOnErr = 0;
    resume = 1; @(negedge clk); resume = 0;
    while (errCount < 4) @(negedge clk);
    userMask = 16'hFFD7;
    @(negedge clk);
    check(errCount == 0 && loopCount == 0, "R10", "mask change clears counters",
          {errCount, loopCount}, 0);
    check(stuckMap == 0 && lastAddr == 0, "R10", "mask change clears logs", stuckMap, 0);
    refLoop(16'hBDFF & userMask);
    while (loopCount != 1) @(negedge clk);
    check(errCount == 16'(refCnt), "R10", "restart from first pattern", errCount, refCnt);
    check(stuckMap == refStuck, "R7", "stuck map after restart", stuckMap, refStuck);
    check(lastAct == refAct && lastExp == refExp && lastAddr == refAddr, "R10", "last log after restart",
          {lastAddr, lastAct, lastExp}, {refAddr, refAct, refExp});
    haltReq = 1; @(negedge clk); haltReq = 0;
    check(!busy, "R11", "idle at end", busy, 0);
    summary();
  end

endmodule